// File: doc/BRIEF.md
# Multi-Width Column Memory with Boot Byte Packer

This block is a synchronous on-chip memory whose storage is a single linear run of 16-bit columns, kept in four physical banks. One access port reads or writes words of 16, 32, 48 or 64 bits, and each width takes one, two, three or four consecutive columns. Every width has its own word-address view, and all the views land on the same cells. A region written as 32-bit words can therefore be read back later as 48-bit instruction words, or as single 16-bit halves. A 48-bit word may cross from one four-column row into the next. The banks handle this by giving each bank its own row address.

A small boot packer sits in front of the port. It takes a byte stream, collects four bytes into each 32-bit word and writes that word at an address that steps up by one after every word. A typical use is a boot loader that streams 1536 bytes. These become 384 packed 32-bit words, which exactly fill a table of 256 48-bit instructions. The core then fetches that table in the 48-bit view.

Top module: `multiwidth_colmem`

## Requirements
- R1: `acc_width` selects how many columns an access covers: code 0 is 16 bits (1 column), code 1 is 32 bits (2 columns), code 2 is 48 bits (3 columns) and code 3 is 64 bits (4 columns).
- R2: Word address k in the view of an n-column width covers columns n*k through n*k+n-1, counted from column 0. The lowest column of a word holds data bits 15:0, the next column holds bits 31:16, and so on.
- R3: All four views alias the same storage. Data written in one width reads back unchanged in any other width, including 48-bit words that cross a four-column row boundary.
- R4: Read data appears on `rd_data` in the cycle after the read is presented. Bits above the access width are zero. In a cycle that follows no read, `rd_data` is all zero.
- R5: A write changes only the columns it covers. The neighbouring columns keep their contents.
- R6: An access whose last column would lie at or beyond `DEPTH_COLS` is out of range. An out-of-range write changes nothing, and an out-of-range read returns zero.
- R7: The packer puts the first byte of each group in bits 7:0 and the fourth byte in bits 31:24. It writes the finished word as a 32-bit access at its current address, one cycle after the fourth byte, and then adds one to that address.
- R8: `boot_load` sets the packer address to `boot_addr` and throws away any partly collected bytes. A byte presented in the same cycle counts as the first byte at the new address.
- R9: When a packer write and a host access fall in the same cycle, the packer write is carried out and the host access is dropped. A dropped read returns zero.
- R10: 384 packed words streamed from 32-bit address 0 fill exactly the 256 48-bit words at 48-bit addresses 0 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the packer and the read pipeline |
| acc_en | input | 1 | Host access request |
| acc_we | input | 1 | Write (1) or read (0) |
| acc_width | input | 2 | Width code (0 = 16-bit, 1 = 32-bit, 2 = 48-bit, 3 = 64-bit) |
| acc_addr | input | ADDR_W | Word address in the view of the selected width |
| acc_wdata | input | 64 | Write data, with the word aligned to bit 0 |
| rd_data | output | 64 | Read data, valid one cycle after the read |
| boot_load | input | 1 | Load the packer address and clear its partly collected bytes |
| boot_addr | input | ADDR_W | Starting address for the packer, in the 32-bit view |
| boot_valid | input | 1 | A boot byte is present |
| boot_byte | input | 8 | Boot byte |

## Verification
The checker watches properties that are visible in every cycle:
- bits above the width of the previous read are zero;
- `rd_data` is zero after a cycle with no read, after an out-of-range read, and after a read that a packer write overrode;
- the number of banks an in-range access enables matches the width code;
- packer writes never come in two cycles in a row, and each one follows a boot byte.

The bench scenarios cover what needs memory of earlier writes:
- aliasing across the four views and across row boundaries;
- leaving neighbouring columns alone;
- dropping out-of-range writes;
- the byte order and address stepping of the packer, and reloading it part-way through a word;
- the full 384-word to 256-instruction table fill, checked against a column model.

// File: rtl/colmem_pkg.sv
package colmem_pkg;
   localparam int COL_W   = 16;
   localparam int NCOL    = 4;
   localparam int DATA_W  = COL_W * NCOL;
   localparam int BYTE_W  = 8;
   localparam int PACK_W  = 2 * COL_W;
   localparam int PACK_N  = PACK_W / BYTE_W;
   localparam int LANE_W  = $clog2(NCOL);

   typedef enum logic [1:0] {
      W16 = 2'd0,
      W32 = 2'd1,
      W48 = 2'd2,
      W64 = 2'd3
   } width_e;
endpackage

// File: rtl/colmem_bank.sv
module colmem_bank #(
   parameter int ROWS  = 256,
   parameter int WID   = 16,
   localparam int RW   = $clog2(ROWS)
) (
   input  logic           clk,
   input  logic           en,
   input  logic           we,
   input  logic [RW-1:0]  row,
   input  logic [WID-1:0] wdata,
   output logic [WID-1:0] rdata
);
   logic [WID-1:0] cells [ROWS];

   always_ff @(posedge clk) begin
      if (en && we) begin
         cells[row] <= wdata;
      end
      if (en && !we) begin
         rdata <= cells[row];
      end
   end
endmodule

// File: rtl/colmem_lane_map.sv
module colmem_lane_map
   import colmem_pkg::*;
#(
   parameter int DEPTH_COLS = 1024,
   parameter int ADDR_W     = 10,
   localparam int ROWS      = DEPTH_COLS / NCOL,
   localparam int ROW_W     = $clog2(ROWS),
   localparam int CW        = ADDR_W + 2
) (
   input  width_e                           width,
   input  logic [ADDR_W-1:0]                addr,
   output logic                             oor,
   output logic [LANE_W-1:0]                start_lane,
   output logic [NCOL-1:0]                  bank_en,
   output logic [NCOL-1:0][ROW_W-1:0]       bank_row,
   output logic [NCOL-1:0][LANE_W-1:0]      bank_off
);
   logic [2:0]    ncols;
   logic [CW-1:0] col_start;
   logic [CW-1:0] col_last;
   logic [ROW_W-1:0] start_row;

   always_comb begin
      unique case (width)
         W16: begin ncols = 3'd1; col_start = {2'b00, addr}; end
         W32: begin ncols = 3'd2; col_start = {1'b0, addr, 1'b0}; end
         W48: begin ncols = 3'd3; col_start = {1'b0, addr, 1'b0} + {2'b00, addr}; end
         default: begin ncols = 3'd4; col_start = {addr, 2'b00}; end
      endcase
      col_last = col_start + {{(CW-3){1'b0}}, ncols} - CW'(1);
      oor = (col_last >= CW'(DEPTH_COLS));
   end

   assign start_lane = col_start[LANE_W-1:0];
   assign start_row  = col_start[ROW_W+LANE_W-1:LANE_W];

   for (genvar b = 0; b < NCOL; b++) begin : g_bank
      logic [LANE_W-1:0] off;
      assign off = LANE_W'(b) - start_lane;
      assign bank_off[b] = off;
      assign bank_en[b]  = !oor && ({1'b0, off} < ncols);
      assign bank_row[b] = (LANE_W'(b) < start_lane) ? start_row + ROW_W'(1) : start_row;
   end
endmodule

// File: rtl/colmem_boot_packer.sv
module colmem_boot_packer
   import colmem_pkg::*;
#(
   parameter int ADDR_W = 10,
   localparam int CNT_W = $clog2(PACK_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              wr,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [PACK_W-1:0] wr_data
);
   logic [CNT_W-1:0]         cnt;
   logic [PACK_W-BYTE_W-1:0] hold;
   logic [ADDR_W-1:0]        cur_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         hold     <= '0;
         cur_addr <= '0;
         wr       <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr <= 1'b0;
         if (load) begin
            cur_addr <= load_addr;
            if (byte_valid) begin
               hold[BYTE_W-1:0] <= byte_in;
               cnt <= CNT_W'(1);
            end else begin
               cnt <= '0;
            end
         end else if (byte_valid) begin
            if (cnt == CNT_W'(PACK_N - 1)) begin
               wr       <= 1'b1;
               wr_addr  <= cur_addr;
               wr_data  <= {byte_in, hold};
               cur_addr <= cur_addr + ADDR_W'(1);
               cnt      <= '0;
            end else begin
               hold[BYTE_W*cnt +: BYTE_W] <= byte_in;
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/multiwidth_colmem.sv
module multiwidth_colmem
   import colmem_pkg::*;
#(
   parameter int DEPTH_COLS = 1024,
   parameter int ADDR_W     = $clog2(DEPTH_COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic [1:0]        acc_width,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] rd_data,
   input  logic              boot_load,
   input  logic [ADDR_W-1:0] boot_addr,
   input  logic              boot_valid,
   input  logic [BYTE_W-1:0] boot_byte
);
   localparam int ROWS  = DEPTH_COLS / NCOL;
   localparam int ROW_W = $clog2(ROWS);

   if (DEPTH_COLS % NCOL != 0) begin : g_bad_depth
      $error("DEPTH_COLS must be a multiple of the column count");
   end
   if (DEPTH_COLS < NCOL) begin : g_small_depth
      $error("DEPTH_COLS must hold at least one row");
   end
   if (ADDR_W < $clog2(DEPTH_COLS)) begin : g_narrow_addr
      $error("ADDR_W too narrow for the 16-bit view");
   end

   // boot packer
   logic              pk_wr;
   logic [ADDR_W-1:0] pk_addr;
   logic [PACK_W-1:0] pk_data;

   colmem_boot_packer #(.ADDR_W(ADDR_W)) u_packer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (boot_load),
      .load_addr  (boot_addr),
      .byte_valid (boot_valid),
      .byte_in    (boot_byte),
      .wr         (pk_wr),
      .wr_addr    (pk_addr),
      .wr_data    (pk_data)
   );

   // port selection: packer write has precedence
   logic              sel_en;
   logic              sel_we;
   width_e            sel_width;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_wdata;

   always_comb begin
      if (pk_wr) begin
         sel_en    = 1'b1;
         sel_we    = 1'b1;
         sel_width = W32;
         sel_addr  = pk_addr;
         sel_wdata = {{(DATA_W-PACK_W){1'b0}}, pk_data};
      end else begin
         sel_en    = acc_en;
         sel_we    = acc_we;
         sel_width = width_e'(acc_width);
         sel_addr  = acc_addr;
         sel_wdata = acc_wdata;
      end
   end

   // lane map
   logic                        map_oor;
   logic [LANE_W-1:0]           map_lane;
   logic [NCOL-1:0]             bank_en;
   logic [NCOL-1:0][ROW_W-1:0]  bank_row;
   logic [NCOL-1:0][LANE_W-1:0] bank_off;

   colmem_lane_map #(.DEPTH_COLS(DEPTH_COLS), .ADDR_W(ADDR_W)) u_map (
      .width      (sel_width),
      .addr       (sel_addr),
      .oor        (map_oor),
      .start_lane (map_lane),
      .bank_en    (bank_en),
      .bank_row   (bank_row),
      .bank_off   (bank_off)
   );

   // column banks
   logic [NCOL-1:0][COL_W-1:0] bank_q;

   for (genvar b = 0; b < NCOL; b++) begin : g_col
      logic [COL_W-1:0] lane_wd;
      assign lane_wd = sel_wdata[COL_W*bank_off[b] +: COL_W];
      colmem_bank #(.ROWS(ROWS), .WID(COL_W)) u_bank (
         .clk   (clk),
         .en    (sel_en && bank_en[b]),
         .we    (sel_we),
         .row   (bank_row[b]),
         .wdata (lane_wd),
         .rdata (bank_q[b])
      );
   end

   // read pipeline and realignment
   logic              rd_pend;
   logic [LANE_W-1:0] rd_lane;
   logic [1:0]        rd_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         rd_lane <= '0;
         rd_w    <= '0;
      end else begin
         rd_pend <= sel_en && !sel_we && !map_oor;
         rd_lane <= map_lane;
         rd_w    <= sel_width;
      end
   end

   for (genvar o = 0; o < NCOL; o++) begin : g_out
      logic [LANE_W-1:0] src;
      assign src = rd_lane + LANE_W'(o);
      assign rd_data[COL_W*o +: COL_W] =
         (rd_pend && (3'(o) <= {1'b0, rd_w})) ? bank_q[src] : '0;
   end
endmodule

// File: rtl/colmem_checker.sv
module colmem_checker
   import colmem_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              acc_we,
   input logic [1:0]        acc_width,
   input logic [DATA_W-1:0] rd_data,
   input logic              boot_valid,
   input logic              pk_wr,
   input logic              map_oor,
   input logic [NCOL-1:0]   bank_en
);
   // R4: upper bits zero after narrow reads
   a_r4_upper_zero_16: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_en && !acc_we && acc_width == 2'd0) |-> rd_data[DATA_W-1:COL_W] == '0);
   a_r4_upper_zero_48: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_en && !acc_we && acc_width == 2'd2) |-> rd_data[DATA_W-1:3*COL_W] == '0);

   // R4: no read last cycle -> zero output
   a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(acc_en && !acc_we) |-> rd_data == '0);

   // R6: out-of-range host read returns zero
   a_r6_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_en && !acc_we && !pk_wr && map_oor) |-> rd_data == '0);

   // R1: in-range host access enables width+1 banks
   a_r1_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !pk_wr && !map_oor) |-> $countones(bank_en) == int'(acc_width) + 1);

   // R7: packer writes are separated and follow a byte
   a_r7_pack_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      pk_wr |=> !pk_wr);
   a_r7_pack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      pk_wr |-> $past(boot_valid));

   // R9: host read overridden by packer write returns zero
   a_r9_pack_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pk_wr && acc_en && !acc_we) |-> rd_data == '0);
endmodule

bind multiwidth_colmem colmem_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_en     (acc_en),
   .acc_we     (acc_we),
   .acc_width  (acc_width),
   .rd_data    (rd_data),
   .boot_valid (boot_valid),
   .pk_wr      (pk_wr),
   .map_oor    (map_oor),
   .bank_en    (bank_en)
);

// File: tb/multiwidth_colmem_test.sv
module multiwidth_colmem_test;
   localparam int DEPTH = 1024;
   localparam int AW    = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_en = 1'b0, acc_we = 1'b0;
   logic [1:0]    acc_width = 2'd0;
   logic [AW-1:0] acc_addr = '0;
   logic [63:0]   acc_wdata = '0;
   logic [63:0]   rd_data;
   logic          boot_load = 1'b0, boot_valid = 1'b0;
   logic [AW-1:0] boot_addr = '0;
   logic [7:0]    boot_byte = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] ref_c [DEPTH];

   always #10 clk = ~clk;

   multiwidth_colmem #(.DEPTH_COLS(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
      .acc_width(acc_width), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .rd_data(rd_data), .boot_load(boot_load), .boot_addr(boot_addr),
      .boot_valid(boot_valid), .boot_byte(boot_byte)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit ref_oor(input int w, input int a);
      return (a * (w + 1) + w) >= DEPTH;
   endfunction

   function automatic void ref_write(input int w, input int a, input logic [63:0] d);
      if (!ref_oor(w, a))
         for (int i = 0; i <= w; i++) ref_c[a * (w + 1) + i] = d[16*i +: 16];
   endfunction

   function automatic logic [63:0] ref_read(input int w, input int a);
      logic [63:0] r = '0;
      if (!ref_oor(w, a))
         for (int i = 0; i <= w; i++) r[16*i +: 16] = ref_c[a * (w + 1) + i];
      return r;
   endfunction

   task automatic do_write(input int w, input int a, input logic [63:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b1; acc_width = 2'(w); acc_addr = AW'(a); acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_we = 1'b0;
      ref_write(w, a, d);
   endtask

   task automatic do_read(input int w, input int a, output logic [63:0] q);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b0; acc_width = 2'(w); acc_addr = AW'(a);
      @(negedge clk);
      q = rd_data;
      acc_en = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      boot_valid = 1'b1; boot_byte = b;
   endtask

   task automatic boot_idle();
      @(negedge clk);
      boot_valid = 1'b0; boot_load = 1'b0;
   endtask

   task automatic t_reset();
      check("R4 reset output", rd_data, 64'h0);
   endtask

   task automatic t_long_to_short();
      logic [63:0] q;
      do_write(3, 2, 64'h4444_3333_2222_1111);
      for (int i = 0; i < 4; i++) begin
         do_read(0, 8 + i, q);
         check("R2 short lane of long word", q, 64'(16'h1111 * (i + 1)));
      end
      do_read(1, 5, q);
      check("R1 normal upper half", q, 64'h4444_3333);
      do_read(3, 2, q);
      check("R1 long readback", q, 64'h4444_3333_2222_1111);
      @(negedge clk);
      check("R4 idle after read", rd_data, 64'h0);
   endtask

   task automatic t_straddle();
      logic [63:0] q;
      do_write(3, 0, 64'hA0A0_A0A0_A0A0_A0A0);
      do_write(3, 1, 64'hB0B0_B0B0_B0B0_B0B0);
      do_write(2, 1, 64'h0000_CCC3_CCC2_CCC1);
      do_read(3, 0, q);
      check("R3 straddle low row", q, ref_read(3, 0));
      do_read(3, 1, q);
      check("R3 straddle high row", q, ref_read(3, 1));
      do_read(2, 1, q);
      check("R3 48-bit readback", q, 64'h0000_CCC3_CCC2_CCC1);
      do_write(1, 8, 64'h0000_0000_1234_5678);
      do_read(2, 5, q);
      check("R3 48 view over 32 write", q, ref_read(2, 5));
   endtask

   task automatic t_neighbors();
      logic [63:0] q;
      do_write(3, 10, 64'h7777_6666_5555_4444);
      do_write(0, 41, 64'hFFFF_FFFF_FFFF_DEAD);
      do_read(3, 10, q);
      check("R5 neighbours kept", q, 64'h7777_6666_DEAD_4444);
      do_read(0, 41, q);
      check("R4 short read upper zero", q, 64'h0000_0000_0000_DEAD);
   endtask

   task automatic t_out_of_range();
      logic [63:0] q;
      do_write(0, 1023, 64'h0000_0000_0000_5A5A);
      do_write(2, 341, 64'h0000_9999_8888_7777);
      do_read(0, 1023, q);
      check("R6 oor write ignored", q, 64'h5A5A);
      do_read(2, 341, q);
      check("R6 oor read zero", q, 64'h0);
      do_read(2, 340, q);
      check("R6 last in-range 48", q, ref_read(2, 340));
   endtask

   task automatic t_pack_basic();
      logic [63:0] q;
      @(negedge clk);
      boot_load = 1'b1; boot_addr = AW'(450);
      @(negedge clk);
      boot_load = 1'b0;
      send_byte(8'h11); send_byte(8'h22);
      @(negedge clk);
      boot_load = 1'b1; boot_addr = AW'(460); boot_valid = 1'b1; boot_byte = 8'hA1;
      @(negedge clk);
      boot_load = 1'b0; boot_byte = 8'hB2;
      send_byte(8'hC3); send_byte(8'hD4);
      send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
      boot_idle(); boot_idle();
      ref_write(1, 460, 64'hD4C3_B2A1);
      ref_write(1, 461, 64'h0403_0201);
      do_read(1, 460, q);
      check("R7 byte order", q, 64'hD4C3_B2A1);
      check("R8 reload discards partial", q, 64'hD4C3_B2A1);
      do_read(1, 461, q);
      check("R7 address increment", q, 64'h0403_0201);
   endtask

   task automatic t_collision();
      logic [63:0] q;
      do_write(0, 900, 64'h1111);
      @(negedge clk);
      boot_load = 1'b1; boot_addr = AW'(400);
      @(negedge clk);
      boot_load = 1'b0;
      send_byte(8'hE1); send_byte(8'hE2); send_byte(8'hE3); send_byte(8'hE4);
      @(negedge clk);
      boot_valid = 1'b0;
      acc_en = 1'b1; acc_we = 1'b1; acc_width = 2'd0; acc_addr = AW'(900); acc_wdata = 64'hBEEF;
      @(negedge clk);
      acc_en = 1'b0; acc_we = 1'b0;
      ref_write(1, 400, 64'hE4E3_E2E1);
      do_read(0, 900, q);
      check("R9 host write dropped", q, 64'h1111);
      do_read(1, 400, q);
      check("R9 packer write done", q, 64'hE4E3_E2E1);
   endtask

   task automatic t_vector_table();
      logic [63:0] q;
      int bad = 0;
      @(negedge clk);
      boot_load = 1'b1; boot_addr = '0;
      @(negedge clk);
      boot_load = 1'b0;
      for (int i = 0; i < 1536; i++) send_byte(8'((i * 37 + 5) & 8'hFF));
      boot_idle(); boot_idle();
      for (int w = 0; w < 384; w++) begin
         logic [31:0] word;
         for (int k = 0; k < 4; k++) word[8*k +: 8] = 8'(((4 * w + k) * 37 + 5) & 8'hFF);
         ref_write(1, w, {32'h0, word});
      end
      for (int j = 0; j < 256; j++) begin
         do_read(2, j, q);
         if (q !== ref_read(2, j)) bad++;
         check("R10 table word", q, ref_read(2, j));
      end
      do_read(3, 191, q);
      check("R10 table end", q, ref_read(3, 191));
      check("R10 mismatch count", 64'(bad), 64'h0);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_c[i] = 16'h0;
      // preload whole memory to a known state through the port
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      for (int l = 0; l < DEPTH / 4; l++) do_write(3, l, 64'h0);
      t_long_to_short();
      t_straddle();
      t_neighbors();
      t_out_of_range();
      t_pack_basic();
      t_collision();
      t_vector_table();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule